// File: doc/BRIEF.md
# Tile Plane Row Fetcher

This block turns one row of one cell of a background tile plane into eight 24-bit RGB pixels. A request gives a cell column, a cell row, the pixel row within the cell (0 to 7) and the plane (first or second). The block works out where that cell's 16-bit name entry sits in video RAM, reads it as two bytes, and takes the tile index and the palette from it. It then reads the four pattern bytes for the requested row, splits each byte into two 4-bit colour indices, and looks each one up in colour RAM. The 12-bit colour words that come back are widened to 24-bit RGB.

Plane geometry is set by configuration inputs that are sampled when a request is accepted. These are a base code for each plane, a plane-width code, and two mode bits that pick the visible width and height in cells. Requests for cells outside the visible area are dropped. Both memories are synchronous: read data is valid in the cycle after the read strobe. One pixel leaves per cycle once the burst starts.

Top module: `tile_row_fetcher`

## Requirements
- R1: While reset is held and after it is released, `busy`, `pix_valid`, `vram_rd` and `cram_rd` are low until a request is accepted.
- R2: The entry address is plane base + 2 × (column + row × plane width), taken modulo 2^16. The first plane's base is `cfg_base_a` × 1024 and the second plane's base is `cfg_base_b` × 8192. The entry is read high byte first at that address, then the low byte at the next address.
- R3: `cfg_width_code` selects the plane width: 0 gives 32 cells, 1 gives 64, 3 gives 128. The reserved code 2 acts as 32.
- R4: The four pattern bytes are read at consecutive addresses starting at (entry bits 10:0) × 32 + 4 × `cell_row`.
- R5: Each pattern byte yields two pixels, the value in bits 7:4 first and then bits 3:0. The eight pixels leave in byte order.
- R6: Each colour lookup reads colour RAM at byte address 2 × (palette × 16 + pixel value), where the palette is entry bits 14:13.
- R7: The colour word maps to `pix_rgb` as follows: bits 3:0 go to 23:20, bits 7:4 go to 15:12, and bits 11:8 go to 7:4. All other output bits are 0, and word bits 15:12 are ignored.
- R8: A start whose column is not below 32 (40 when `cfg_h40` is 1), or whose row is not below 28 (30 when `cfg_v30` is 1), is dropped. No read is issued, no pixel is produced and `busy` stays low.
- R9: A start that arrives while `busy` is high is ignored. The running request completes unchanged.
- R10: An accepted start raises `busy` in the next cycle. The first pixel is valid after the seventh rising edge, counting the edge that samples the start. The eight pixels are valid on eight consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| plane_b | input | 1 | 0 selects the first plane, 1 the second |
| cell_x | input | 7 | Cell column |
| cell_y | input | 7 | Cell row |
| cell_row | input | 3 | Pixel row inside the cell |
| cfg_base_a | input | 8 | Name-table base code, first plane |
| cfg_base_b | input | 8 | Name-table base code, second plane |
| cfg_width_code | input | 2 | Plane width code |
| cfg_h40 | input | 1 | Visible width 40 cells when 1, else 32 |
| cfg_v30 | input | 1 | Visible height 30 cells when 1, else 28 |
| vram_rd | output | 1 | Video RAM read strobe |
| vram_addr | output | 16 | Video RAM byte address |
| vram_data | input | 8 | Video RAM read data, valid one cycle after the strobe |
| cram_rd | output | 1 | Colour RAM read strobe |
| cram_addr | output | 7 | Colour RAM byte address |
| cram_data | input | 16 | Colour RAM word, valid one cycle after the strobe |
| busy | output | 1 | Request in progress |
| pix_valid | output | 1 | Pixel output valid |
| pix_rgb | output | 24 | Pixel colour |

## Verification
The bench targets several corner cases:
- Each width code, including the reserved one. A wrong shift moves every entry read for rows past zero.
- Entry addresses that wrap past 16 bits. A design that widens the sum reads the wrong byte.
- Visibility edges at columns 31/32 and 39/40 and rows 27/28 and 29/30. An off-by-one comparison either drops a visible cell or fetches a hidden one.
- A second start landing mid-burst. This exposes a design that relatches coordinates.
- Colour words with nonzero top nibbles, along with pattern bytes whose two halves differ. These catch swapped nibble order, a wrong palette field, or colour channels placed in the wrong positions.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EHI,
    S_ELO,
    S_ENT,
    S_PAT,
    S_PXH,
    S_PXL
  } fetch_state_e;

  // log2 of plane width in cells; reserved code behaves as the narrowest
  function automatic logic [2:0] width_shift(input logic [1:0] code);
    unique case (code)
      2'b01:   width_shift = 3'd6;
      2'b11:   width_shift = 3'd7;
      default: width_shift = 3'd5;
    endcase
  endfunction

  // 12-bit colour word to 24-bit RGB, each 4-bit channel in the upper
  // half of its byte lane
  function automatic logic [23:0] widen_color(input logic [11:0] w);
    widen_color = {w[3:0], 4'h0, w[7:4], 4'h0, w[11:8], 4'h0};
  endfunction

endpackage

// File: rtl/tpf_addr_gen.sv
module tpf_addr_gen
  import tpf_pkg::*;
#(
  parameter int COORD_W = 7,
  parameter int VA_W    = 16
) (
  input  logic               plane_b,
  input  logic [7:0]         base_a,
  input  logic [7:0]         base_b,
  input  logic [1:0]         width_code,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  output logic [VA_W-1:0]    entry_addr
);

  localparam int SHIFT_A = 10;
  localparam int SHIFT_B = 13;

  logic [VA_W-1:0] base;
  logic [VA_W-1:0] row_term;
  logic [VA_W-1:0] cell_off;

  always_comb begin
    if (plane_b) base = VA_W'({base_b, {SHIFT_B{1'b0}}});
    else         base = VA_W'({base_a, {SHIFT_A{1'b0}}});
    row_term   = VA_W'(row) << width_shift(width_code);
    cell_off   = (VA_W'(col) + row_term) << 1;
    entry_addr = base + cell_off;
  end

endmodule

// File: rtl/tpf_seq.sv
module tpf_seq
  import tpf_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int CA_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [VA_W-1:0] entry_addr,
  input  logic [2:0]      row,
  input  logic [7:0]      vram_data,
  output logic            vram_rd,
  output logic [VA_W-1:0] vram_addr,
  output logic            cram_rd,
  output logic [CA_W-1:0] cram_addr,
  output logic            busy
);

  localparam logic [1:0] LAST_BYTE = 2'd3;

  fetch_state_e state_q, state_d;
  logic [1:0]   pal_q;
  logic [10:0]  tile_q;
  logic [7:0]   byte_q;
  logic [1:0]   idx_q;
  logic         hi_en, lo_en, byte_en, idx_clr, idx_inc;
  logic [1:0]   rd_idx;
  logic         unused_entry_bits;

  assign unused_entry_bits = ^{vram_data[7], vram_data[4:3]};
  assign busy = (state_q != S_IDLE);

  always_comb begin
    state_d   = state_q;
    vram_rd   = 1'b0;
    vram_addr = '0;
    cram_rd   = 1'b0;
    cram_addr = '0;
    hi_en     = 1'b0;
    lo_en     = 1'b0;
    byte_en   = 1'b0;
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    rd_idx    = idx_q;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          idx_clr = 1'b1;
          state_d = S_EHI;
        end
      end
      S_EHI: begin
        vram_rd   = 1'b1;
        vram_addr = entry_addr;
        state_d   = S_ELO;
      end
      S_ELO: begin
        vram_rd   = 1'b1;
        vram_addr = entry_addr + VA_W'(1);
        hi_en     = 1'b1;
        state_d   = S_ENT;
      end
      S_ENT: begin
        lo_en   = 1'b1;
        state_d = S_PAT;
      end
      S_PAT: begin
        vram_rd   = 1'b1;
        vram_addr = VA_W'({tile_q, row, rd_idx});
        state_d   = S_PXH;
      end
      S_PXH: begin
        byte_en   = 1'b1;
        cram_rd   = 1'b1;
        cram_addr = CA_W'({pal_q, vram_data[7:4], 1'b0});
        state_d   = S_PXL;
      end
      S_PXL: begin
        cram_rd   = 1'b1;
        cram_addr = CA_W'({pal_q, byte_q[3:0], 1'b0});
        idx_inc   = 1'b1;
        if (idx_q == LAST_BYTE) begin
          state_d = S_IDLE;
        end else begin
          rd_idx    = idx_q + 2'd1;
          vram_rd   = 1'b1;
          vram_addr = VA_W'({tile_q, row, rd_idx});
          state_d   = S_PXH;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      if (idx_clr)      idx_q <= 2'd0;
      else if (idx_inc) idx_q <= idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (hi_en) begin
      pal_q         <= vram_data[6:5];
      tile_q[10:8]  <= vram_data[2:0];
    end
    if (lo_en)   tile_q[7:0] <= vram_data;
    if (byte_en) byte_q      <= vram_data;
  end

  // R2: low entry byte is read at the address right after the high byte
  a_r2_entry_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ELO) |-> (vram_rd && vram_addr == $past(vram_addr) + VA_W'(1)));

  // R4: successive pattern reads step by one byte, two cycles apart
  a_r4_pattern_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PXL && vram_rd) |-> (vram_addr == $past(vram_addr, 2) + VA_W'(1)));

endmodule

// File: rtl/tpf_color.sv
module tpf_color
  import tpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cram_rd,
  input  logic [15:0] cram_data,
  output logic        pix_valid,
  output logic [23:0] pix_rgb
);

  logic        pend_q;
  logic        vld_q;
  logic [23:0] rgb_q;
  logic        unused_cram_top;

  assign unused_cram_top = ^cram_data[15:12];
  assign pix_valid = vld_q;
  assign pix_rgb   = rgb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= cram_rd;
      vld_q  <= pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q) rgb_q <= widen_color(cram_data[11:0]);
  end

  // R10: every pixel traces back to a colour read two cycles earlier
  a_r10_pix_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(cram_rd, 2));

  // R5: pixels leave in pairs, one pair per pattern byte
  a_r5_pixel_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !$past(pix_valid)) |=> pix_valid);

endmodule

// File: rtl/tile_row_fetcher.sv
module tile_row_fetcher
  import tpf_pkg::*;
#(
  parameter int COORD_W  = 7,
  parameter int VA_W     = 16,
  parameter int H_NARROW = 32,
  parameter int H_WIDE   = 40,
  parameter int V_SHORT  = 28,
  parameter int V_TALL   = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               plane_b,
  input  logic [COORD_W-1:0] cell_x,
  input  logic [COORD_W-1:0] cell_y,
  input  logic [2:0]         cell_row,
  input  logic [7:0]         cfg_base_a,
  input  logic [7:0]         cfg_base_b,
  input  logic [1:0]         cfg_width_code,
  input  logic               cfg_h40,
  input  logic               cfg_v30,
  output logic               vram_rd,
  output logic [VA_W-1:0]    vram_addr,
  input  logic [7:0]         vram_data,
  output logic               cram_rd,
  output logic [6:0]         cram_addr,
  input  logic [15:0]        cram_data,
  output logic               busy,
  output logic               pix_valid,
  output logic [23:0]        pix_rgb
);

  localparam int CA_W = 7;
  localparam logic [COORD_W-1:0] LIM_HN = COORD_W'(H_NARROW);
  localparam logic [COORD_W-1:0] LIM_HW = COORD_W'(H_WIDE);
  localparam logic [COORD_W-1:0] LIM_VS = COORD_W'(V_SHORT);
  localparam logic [COORD_W-1:0] LIM_VT = COORD_W'(V_TALL);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic               visible, accept;
  logic               plane_q;
  logic [COORD_W-1:0] x_q, y_q;
  logic [2:0]         row_q;
  logic [7:0]         ba_q, bb_q;
  logic [1:0]         wc_q;
  logic [VA_W-1:0]    entry_addr;

  always_comb begin
    visible = (cell_x < (cfg_h40 ? LIM_HW : LIM_HN)) &&
              (cell_y < (cfg_v30 ? LIM_VT : LIM_VS));
    accept  = start && visible && !busy;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      plane_q <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      row_q   <= '0;
      ba_q    <= '0;
      bb_q    <= '0;
      wc_q    <= '0;
    end else if (accept) begin
      plane_q <= plane_b;
      x_q     <= cell_x;
      y_q     <= cell_y;
      row_q   <= cell_row;
      ba_q    <= cfg_base_a;
      bb_q    <= cfg_base_b;
      wc_q    <= cfg_width_code;
    end
  end

  tpf_addr_gen #(.COORD_W(COORD_W), .VA_W(VA_W)) i_addr (
    .plane_b    (plane_q),
    .base_a     (ba_q),
    .base_b     (bb_q),
    .width_code (wc_q),
    .col        (x_q),
    .row        (y_q),
    .entry_addr (entry_addr)
  );

  tpf_seq #(.VA_W(VA_W), .CA_W(CA_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .accept     (accept),
    .entry_addr (entry_addr),
    .row        (row_q),
    .vram_data  (vram_data),
    .vram_rd    (vram_rd),
    .vram_addr  (vram_addr),
    .cram_rd    (cram_rd),
    .cram_addr  (cram_addr),
    .busy       (busy)
  );

  tpf_color i_color (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cram_rd   (cram_rd),
    .cram_data (cram_data),
    .pix_valid (pix_valid),
    .pix_rgb   (pix_rgb)
  );

  // R8: a start outside the visible area leaves the block idle
  a_r8_hidden_dropped: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start && !busy && !visible) |=> !busy);

  // R9: the latched request cannot change while a fetch runs
  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |=> ($stable(x_q) && $stable(y_q) && $stable(row_q) && $stable(plane_q)));

endmodule

// File: tb/test_tile_row_fetcher.sv
module test_tile_row_fetcher;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, plane_b;
  logic [6:0]  cell_x, cell_y;
  logic [2:0]  cell_row;
  logic [7:0]  cfg_base_a, cfg_base_b;
  logic [1:0]  cfg_width_code;
  logic        cfg_h40, cfg_v30;
  logic        vram_rd, cram_rd, busy, pix_valid;
  logic [15:0] vram_addr;
  logic [7:0]  vram_data;
  logic [6:0]  cram_addr;
  logic [15:0] cram_data;
  logic [23:0] pix_rgb;

  int n_chk = 0, n_bad = 0;
  int vseed = 0, cseed = 0;
  bit done = 0;
  int vlog [0:4095];
  int clog [0:4095];
  int vlog_n = 0, clog_n = 0;

  tile_row_fetcher i_tile_row_fetcher (
    .clk(clk), .rst_n(rst_n), .start(start), .plane_b(plane_b),
    .cell_x(cell_x), .cell_y(cell_y), .cell_row(cell_row),
    .cfg_base_a(cfg_base_a), .cfg_base_b(cfg_base_b),
    .cfg_width_code(cfg_width_code), .cfg_h40(cfg_h40), .cfg_v30(cfg_v30),
    .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_data(vram_data),
    .cram_rd(cram_rd), .cram_addr(cram_addr), .cram_data(cram_data),
    .busy(busy), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] vbyte(input int a);
    int t;
    t = a * 149 + (a >> 7) * 31 + vseed;
    return t[7:0];
  endfunction

  function automatic logic [15:0] cword(input int a);
    int t;
    t = a * 2659 + cseed * 7 + 40961;
    return t[15:0];
  endfunction

  // synchronous memory models and read logs
  always @(posedge clk) begin
    if (vram_rd) begin
      vram_data <= vbyte(int'(vram_addr));
      vlog[vlog_n & 4095] = int'(vram_addr);
      vlog_n = vlog_n + 1;
    end
    if (cram_rd) begin
      cram_data <= cword(int'(cram_addr));
      clog[clog_n & 4095] = int'(cram_addr);
      clog_n = clog_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_entry(input bit pb, input int x, input int y,
                                   input int ba, input int bb, input int wc);
    int w, base;
    w    = (wc == 1) ? 64 : (wc == 3) ? 128 : 32;
    base = pb ? bb * 8192 : ba * 1024;
    return (base + 2 * (x + y * w)) % 65536;
  endfunction

  function automatic int exp_rgb(input int c);
    return ((c % 16) * 1048576) + (((c / 16) % 16) * 4096) + (((c / 256) % 16) * 16);
  endfunction

  task automatic run_req(input bit pb, input int x, input int y, input int row,
                         input int ba, input int bb, input int wc,
                         input bit h40, input bit v30, input bit vis,
                         input bit restart, input string tag);
    int v0, c0, np, first_cyc, last_cyc, ea, ent, pat, pal;
    bit gap, busy_seen;
    int pix [0:15];
    v0 = vlog_n; c0 = clog_n;
    @(negedge clk);
    plane_b = pb; cell_x = 7'(x); cell_y = 7'(y); cell_row = 3'(row);
    cfg_base_a = 8'(ba); cfg_base_b = 8'(bb); cfg_width_code = 2'(wc);
    cfg_h40 = h40; cfg_v30 = v30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    np = 0; first_cyc = -1; last_cyc = -1; gap = 0; busy_seen = 0;
    if (vis) check(busy === 1'b1, {"R10 busy after start ", tag}, int'(busy), 1);
    for (int cyc = 1; cyc <= 26; cyc++) begin
      if (busy) busy_seen = 1;
      if (pix_valid) begin
        if (np < 16) pix[np] = int'(pix_rgb);
        if (np == 0) first_cyc = cyc;
        else if (cyc != last_cyc + 1) gap = 1;
        last_cyc = cyc;
        np++;
      end
      if (restart && cyc == 3) begin
        cell_x = 7'((x + 5) % 32); cell_row = 3'(row + 1); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    if (!vis) begin
      check(np == 0, {"R8 no pixels ", tag}, np, 0);
      check(!busy_seen, {"R8 busy stays low ", tag}, int'(busy_seen), 0);
      check(vlog_n == v0 && clog_n == c0, {"R8 no reads ", tag}, vlog_n - v0, 0);
      return;
    end
    ea  = exp_entry(pb, x, y, ba, bb, wc);
    ent = int'(vbyte(ea)) * 256 + int'(vbyte((ea + 1) % 65536));
    pat = (ent % 2048) * 32 + row * 4;
    pal = (ent / 8192) % 4;
    check(vlog_n - v0 == 6, {"R9 read count ", tag}, vlog_n - v0, 6);
    check(vlog[v0 & 4095] == ea, {"R2/R3 entry high addr ", tag}, vlog[v0 & 4095], ea);
    check(vlog[(v0 + 1) & 4095] == (ea + 1) % 65536, {"R2 entry low addr ", tag},
          vlog[(v0 + 1) & 4095], (ea + 1) % 65536);
    for (int b = 0; b < 4; b++)
      check(vlog[(v0 + 2 + b) & 4095] == pat + b, {"R4 pattern addr ", tag},
            vlog[(v0 + 2 + b) & 4095], pat + b);
    check(np == 8, {"R5 pixel count ", tag}, np, 8);
    check(first_cyc == 7 && !gap, {"R10 pixel timing ", tag}, first_cyc, 7);
    for (int k = 0; k < 8; k++) begin
      int byt, nib, ca;
      byt = int'(vbyte(pat + k / 2));
      nib = (k % 2 == 0) ? byt / 16 : byt % 16;
      ca  = 2 * (pal * 16 + nib);
      check(clog[(c0 + k) & 4095] == ca, {"R6 colour addr ", tag}, clog[(c0 + k) & 4095], ca);
      if (k < np)
        check(pix[k] == exp_rgb(int'(cword(ca))), {"R5/R7 pixel ", tag}, pix[k],
              exp_rgb(int'(cword(ca))));
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; plane_b = 1'b0; cell_x = '0; cell_y = '0;
    cell_row = '0; cfg_base_a = '0; cfg_base_b = '0; cfg_width_code = '0;
    cfg_h40 = 1'b0; cfg_v30 = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && pix_valid === 1'b0, "R1 outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && pix_valid === 1'b0 && vram_rd === 1'b0 && cram_rd === 1'b0,
          "R1 idle after reset", int'({busy, pix_valid, vram_rd, cram_rd}), 0);

    // R3: every width code including the reserved one
    for (int wc = 0; wc < 4; wc++) run_req(0, 3, 2, 1, 8'h12, 0, wc, 0, 0, 1, 0, "R3 width");
    // R2: second plane, base wrap past 16 bits
    run_req(1, 10, 5, 4, 0, 8'h07, 3, 1, 1, 1, 0, "R2 plane b");
    run_req(0, 31, 27, 7, 8'h3F, 0, 3, 0, 0, 1, 0, "R2 wrap");
    // R8: visibility edges
    run_req(0, 31, 0, 0, 1, 1, 0, 0, 0, 1, 0, "R8 col 31");
    run_req(0, 32, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R8 col 32");
    run_req(0, 39, 0, 0, 1, 1, 0, 1, 0, 1, 0, "R8 col 39");
    run_req(0, 40, 0, 0, 1, 1, 0, 1, 0, 0, 0, "R8 col 40");
    run_req(0, 0, 27, 2, 1, 1, 1, 0, 0, 1, 0, "R8 row 27");
    run_req(0, 0, 28, 2, 1, 1, 1, 0, 0, 0, 0, "R8 row 28");
    run_req(0, 0, 29, 2, 1, 1, 1, 0, 1, 1, 0, "R8 row 29");
    run_req(0, 0, 30, 2, 1, 1, 1, 0, 1, 0, 0, "R8 row 30");
    // R9: second start mid-burst
    run_req(1, 6, 9, 3, 4, 5, 1, 0, 0, 1, 1, "R9 restart");

    // random mix with a fixed seed
    void'($urandom(32'd4711));
    for (int i = 0; i < 40; i++) begin
      bit h40, v30;
      vseed = int'($urandom % 256);
      cseed = int'($urandom % 4096);
      h40 = 1'($urandom);
      v30 = 1'($urandom);
      run_req(1'($urandom), int'($urandom % (h40 ? 40 : 32)), int'($urandom % (v30 ? 30 : 28)),
              int'($urandom % 8), int'($urandom % 256), int'($urandom % 256),
              int'($urandom % 4), h40, v30, 1, 0, "R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule